// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards against a hung system by counting down a down-counter from a programmable reload value. When the count reaches zero for the first time, the block raises an interrupt. A control bit routes that interrupt either to a maskable line or to a non-maskable line. The counter then reloads and keeps counting.

If the counter reaches zero a second time before software has cleared the interrupt, the block issues a reset request, provided reset generation is enabled. The request appears as a one-cycle pulse on one of two lines. A control bit selects which line: a system reset or a power-on-class reset.

Software reaches the block through a small write port with four word addresses. Address 0 sets the reload value. Address 1 is the control word. Address 2 acknowledges the interrupt. Address 3 is spare. The current count is always visible on an output.

Top module: `wdt_two_stage`

## Requirements
- R1: After the synchronous reset, the count is all ones, the reload value is all ones, all control bits are 0, and the interrupt outputs and reset outputs are all low.
- R2: While the enable bit (control bit 0) is set, the counter decreases by one on each clock edge at which its value is non-zero.
- R3: At the edge where an enabled counter is at zero, the interrupt becomes pending. The pending interrupt is driven on `irq_o` when control bit 1 is 0, and on `nmi_o` when control bit 1 is 1. The two outputs are never high together.
- R4: On that same zero edge, the counter reloads from the reload value and keeps counting down.
- R5: A zero edge that occurs while the interrupt is already pending produces a reset request, but only when control bit 2 (reset enable) is 1.
- R6: A reset request is a one-cycle pulse, one cycle after that zero edge. It appears on `sys_rst_o` when control bit 3 is 0 and on `por_rst_o` when control bit 3 is 1.
- R7: A write to address 2 deasserts the pending interrupt and reloads the counter from the reload value, whatever the write data.
- R8: When reset enable is 0, a second zero edge produces no reset pulse. The interrupt stays pending and the counter reloads.
- R9: While the enable bit is 0, the count holds. Once the enable bit is set, it can be cleared only by the reset; a control write with bit 0 at 0 leaves the counter running.
- R10: A write to address 0 stores the reload value and also loads it into the counter at the same edge.
- R11: A reload value of zero makes the interrupt pending at the first clock edge after the counter has been loaded with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 reload value, 1 control, 2 interrupt acknowledge, 3 spare |
| wr_data | input | 32 | Write data. For the control word: bit 0 enable, bit 1 non-maskable select, bit 2 reset enable, bit 3 power-on-class reset |
| count_o | output | 32 | Current counter value |
| irq_o | output | 1 | Maskable time-out interrupt |
| nmi_o | output | 1 | Non-maskable time-out interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |
| por_rst_o | output | 1 | One-cycle power-on-class reset request |

## Verification
The time-out path is exercised with short reload values under several control words:
- Maskable and non-maskable routing separates the two interrupt lines.
- Reset enable combined with each reset type separates the two reset pulses, and also separates them from the silent second time-out when reset is disabled.

An acknowledge between the two time-outs shows that the counter restarts and that the next zero is treated as a first time-out, not a second one.

Writing a new reload value in mid-count, and writing a reload value of zero, tell an immediate reload apart from a reload deferred to the next zero.

A control write with the enable bit at 0, made after enabling, shows whether the enable bit is sticky.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Word addresses of the write port.
    typedef enum logic [1:0] {
        ADDR_RELOAD = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_ACK    = 2'd2,
        ADDR_SPARE  = 2'd3
    } wdt_addr_e;

    // Control word. Bit 0 is the enable, bit 3 the reset type.
    typedef struct packed {
        logic por_kind;   // bit 3: 1 = power-on-class reset
        logic rst_en;     // bit 2: reset generation enabled
        logic nmi_sel;    // bit 1: 1 = non-maskable interrupt
        logic run;        // bit 0: counter enable (sticky)
    } wdt_ctrl_t;

    localparam int CTRL_BITS = $bits(wdt_ctrl_t);

    // Merge a control write into the current control state.
    function automatic wdt_ctrl_t ctrl_update(wdt_ctrl_t cur, logic [CTRL_BITS-1:0] data);
        wdt_ctrl_t nxt;
        nxt          = wdt_ctrl_t'(data);
        nxt.run      = cur.run | data[0];
        return nxt;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] reload_q,
    output wdt_ctrl_t     ctrl_q,
    output logic          reload_wr,
    output logic          ack_wr
);

    wdt_addr_e addr;
    assign addr      = wdt_addr_e'(wr_addr);
    assign reload_wr = wr_en && (addr == ADDR_RELOAD);
    assign ack_wr    = wr_en && (addr == ADDR_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (reload_wr)
                reload_q <= wr_data;
            if (wr_en && addr == ADDR_CTRL)
                ctrl_q <= ctrl_update(ctrl_q, wr_data[CTRL_BITS-1:0]);
        end
    end

    // Enable bit cannot fall except through reset.
    p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> ctrl_q.run);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          reload_wr,
    input  logic [CW-1:0] reload_wdata,
    input  logic          ack_wr,
    input  logic [CW-1:0] reload_q,
    output logic [CW-1:0] count_q,
    output logic          expire
);

    logic reload_now;
    assign reload_now = reload_wr || ack_wr;
    // A software reload takes precedence over a time-out in the same cycle.
    assign expire     = run && !reload_now && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '1;
        else if (reload_wr)
            count_q <= reload_wdata;
        else if (ack_wr || expire)
            count_q <= reload_q;
        else if (run)
            count_q <= count_q - 1'b1;
    end

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !reload_now && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

    p_zero_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !reload_now && count_q == '0) |=> count_q == $past(reload_q));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload_now) |=> $stable(count_q));

endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  logic      ack_wr,
    input  wdt_ctrl_t ctrl_q,
    output logic      pending_q,
    output logic      sys_pulse_q,
    output logic      por_pulse_q
);

    logic second;
    assign second = expire && pending_q && ctrl_q.rst_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q   <= 1'b0;
            sys_pulse_q <= 1'b0;
            por_pulse_q <= 1'b0;
        end else begin
            if (ack_wr)
                pending_q <= 1'b0;
            else if (expire)
                pending_q <= 1'b1;
            sys_pulse_q <= second && !ctrl_q.por_kind;
            por_pulse_q <= second &&  ctrl_q.por_kind;
        end
    end

    p_reset_needs_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (sys_pulse_q || por_pulse_q) |-> ($past(pending_q) && $past(ctrl_q.rst_en)));

    p_one_reset_kind_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sys_pulse_q, por_pulse_q}));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !pending_q);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count_o,
    output logic          irq_o,
    output logic          nmi_o,
    output logic          sys_rst_o,
    output logic          por_rst_o
);

    logic [CW-1:0] reload_q;
    wdt_ctrl_t     ctrl_q;
    logic          reload_wr;
    logic          ack_wr;
    logic          expire;
    logic          pending_q;

    wdt_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reload_q  (reload_q),
        .ctrl_q    (ctrl_q),
        .reload_wr (reload_wr),
        .ack_wr    (ack_wr)
    );

    wdt_counter #(.CW(CW)) u_counter (
        .clk          (clk),
        .rst          (rst),
        .run          (ctrl_q.run),
        .reload_wr    (reload_wr),
        .reload_wdata (wr_data),
        .ack_wr       (ack_wr),
        .reload_q     (reload_q),
        .count_q      (count_o),
        .expire       (expire)
    );

    wdt_stage u_stage (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .ack_wr      (ack_wr),
        .ctrl_q      (ctrl_q),
        .pending_q   (pending_q),
        .sys_pulse_q (sys_rst_o),
        .por_pulse_q (por_rst_o)
    );

    assign irq_o = pending_q && !ctrl_q.nmi_sel;
    assign nmi_o = pending_q &&  ctrl_q.nmi_sel;

    p_irq_lines_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(irq_o && nmi_o));

endmodule

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o;
    logic        irq_o, nmi_o, sys_rst_o, por_rst_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 4 ns period

    wdt_two_stage u_wdt_two_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .count_o   (count_o),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .sys_rst_o (sys_rst_o),
        .por_rst_o (por_rst_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    // Reload 3, enable with given control, then run to the first time-out.
    task automatic to_first(input logic [31:0] ctl);
        do_reset();
        wr(2'd0, 32'd3);
        wr(2'd1, ctl);
        tick(4);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1", "count", count_o, 32'hFFFF_FFFF);
        check("R1", "outputs", {28'd0, irq_o, nmi_o, sys_rst_o, por_rst_o}, 32'd0);
    endtask

    task automatic t_first_timeout();
        do_reset();
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h1);
        check("R2", "count after enable", count_o, 32'd3);
        tick(3);
        check("R2", "count at zero", count_o, 32'd0);
        check("R3", "irq before zero edge", {31'd0, irq_o}, 32'd0);
        tick(1);
        check("R3", "irq after first zero", {31'd0, irq_o}, 32'd1);
        check("R3", "nmi quiet", {31'd0, nmi_o}, 32'd0);
        check("R4", "reloaded", count_o, 32'd3);
        tick(1);
        check("R4", "keeps counting", count_o, 32'd2);
    endtask

    task automatic t_nmi();
        to_first(32'h3);
        check("R3", "nmi asserted", {31'd0, nmi_o}, 32'd1);
        check("R3", "irq quiet in nmi mode", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_sys_reset();
        to_first(32'h5);
        tick(3);
        check("R5", "no pulse before second zero", {31'd0, sys_rst_o}, 32'd0);
        tick(1);
        check("R6", "system pulse", {31'd0, sys_rst_o}, 32'd1);
        check("R6", "power-on quiet", {31'd0, por_rst_o}, 32'd0);
        tick(1);
        check("R6", "pulse one cycle", {31'd0, sys_rst_o}, 32'd0);
    endtask

    task automatic t_por_reset();
        to_first(32'hD);
        tick(4);
        check("R6", "power-on pulse", {31'd0, por_rst_o}, 32'd1);
        check("R6", "system quiet", {31'd0, sys_rst_o}, 32'd0);
        tick(1);
        check("R6", "por pulse one cycle", {31'd0, por_rst_o}, 32'd0);
    endtask

    task automatic t_ack();
        to_first(32'h5);
        tick(2);
        wr(2'd2, 32'hDEAD);
        check("R7", "irq cleared", {31'd0, irq_o}, 32'd0);
        check("R7", "count reloaded", count_o, 32'd3);
        tick(4);
        check("R7", "fresh first timeout no reset", {31'd0, sys_rst_o}, 32'd0);
        check("R7", "irq again", {31'd0, irq_o}, 32'd1);
    endtask

    task automatic t_no_reset();
        to_first(32'h1);
        tick(4);
        check("R8", "no sys pulse", {31'd0, sys_rst_o}, 32'd0);
        check("R8", "no por pulse", {31'd0, por_rst_o}, 32'd0);
        check("R8", "irq held", {31'd0, irq_o}, 32'd1);
        check("R8", "reloaded", count_o, 32'd3);
    endtask

    task automatic t_enable_hold();
        do_reset();
        wr(2'd0, 32'd5);
        tick(3);
        check("R9", "hold while disabled", count_o, 32'd5);
        wr(2'd1, 32'h1);
        tick(1);
        check("R9", "running", count_o, 32'd4);
        wr(2'd1, 32'h0);
        check("R9", "write of 0 keeps run", count_o, 32'd3);
        tick(1);
        check("R9", "still running", count_o, 32'd2);
    endtask

    task automatic t_reload_write();
        do_reset();
        wr(2'd0, 32'd10);
        wr(2'd1, 32'h1);
        tick(2);
        check("R10", "mid count", count_o, 32'd8);
        wr(2'd0, 32'd7);
        check("R10", "immediate load", count_o, 32'd7);
        tick(1);
        check("R10", "continues from new", count_o, 32'd6);
        wr(2'd0, 32'd0);
        check("R11", "zero loaded no irq yet", {31'd0, irq_o}, 32'd0);
        tick(1);
        check("R11", "irq next clock", {31'd0, irq_o}, 32'd1);
    endtask

    initial begin
        t_reset_state();
        t_first_timeout();
        t_nmi();
        t_sys_reset();
        t_por_reset();
        t_ack();
        t_no_reset();
        t_enable_hold();
        t_reload_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule